// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Jump Targets

This block holds the program counter of a 32-bit processor whose instructions are all one 32-bit word. In every cycle it looks at the instruction just fetched and works out the address of the next one. Most instructions simply fall through to the following word. A conditional branch adds a signed word offset to that following address. A pseudo-direct jump builds a full address from a 26-bit word index. A register jump loads an address taken straight from an operand value.

The surrounding pipeline supplies the instruction word, the two operand values that a conditional branch compares, and the operand used by register jumps. The next address is available combinationally on `pc_next`. The register behind `pc` only takes that value on a clock edge while `step_en` is high, so the fetch stage can stall. For the jump-and-link instruction the block also drives a return address and a write request aimed at register 31.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is forced to the parameter `RESET_PC`, whose default is 0x0040_0000. That value is still present after reset is released and before the first enabled step.
- R2: On a clock edge where `step_en` is low, `pc` keeps its value, whatever the instruction is.
- R3: On a clock edge where `step_en` is high, `pc` takes the value `pc_next` had before that edge. An instruction whose opcode (bits 31..26) is not 0, 2, 3, 4 or 5 gives `pc_next = pc + 4`.
- R4: Opcode 4 (branch-if-equal) gives `pc_next = pc + 4 + (sign-extended bits 15..0) * 4` when `rs_val == rt_val`, and `pc + 4` otherwise.
- R5: Opcode 5 (branch-if-different) gives the same offset target when `rs_val != rt_val`, and `pc + 4` otherwise.
- R6: A branch offset with bit 15 set moves the target backwards. For example, offset 0xFFFE gives `pc + 4 - 8`.
- R7: Opcode 2 (jump) gives `pc_next = {bits 31..28 of pc + 4, instruction bits 25..0, 2'b00}`.
- R8: Opcode 3 (jump-and-link) gives the same target as R7 and raises `link_we`, with `link_addr = pc + 4` and `link_reg = 31`. For every other instruction, `link_we` is low.
- R9: Opcode 0 with function field (bits 5..0) equal to 8 gives `pc_next = jr_target`. Opcode 0 with any other function value gives `pc + 4`.
- R10: The upper four bits of a jump target come from `pc + 4` and not from `pc`. At `pc = 0x0FFF_FFFC`, a jump with index 5 goes to 0x1000_0014.
- R11: Sequential advance wraps modulo 2^32, so `pc = 0xFFFF_FFFC` gives `pc_next = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Allows the PC register to advance |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | First compared operand |
| rt_val | input | 32 | Second compared operand |
| jr_target | input | 32 | Operand value used by a register jump |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address of the next instruction |
| link_addr | output | 32 | Return address for jump-and-link |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Register index for the return address |

## Verification
The outputs `pc_next`, `link_addr` and `link_we` are combinational, so they are due in the same cycle the instruction is presented. The bench drives each instruction just after a falling edge and samples these outputs 1 ns later, well before the next rising edge. The new `pc` is due one rising edge after an enabled step. The driver queues that expected value, and a monitor pops it and compares it 1 ns after the rising edge. Disabled steps queue the unchanged PC, so hold behaviour is checked on the same schedule.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int ADDR_W   = 32;
    localparam int OPC_W    = 6;
    localparam int FUNCT_W  = 6;
    localparam int IMM_W    = 16;
    localparam int INDEX_W  = 26;
    localparam int REGIDX_W = 5;
    localparam int REGION_W = ADDR_W - INDEX_W - 2;
    localparam int SEXT_W   = ADDR_W - IMM_W - 2;

    localparam logic [OPC_W-1:0]    OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0]    OPC_JUMP    = 6'd2;
    localparam logic [OPC_W-1:0]    OPC_JLINK   = 6'd3;
    localparam logic [OPC_W-1:0]    OPC_BREQ    = 6'd4;
    localparam logic [OPC_W-1:0]    OPC_BRNE    = 6'd5;
    localparam logic [FUNCT_W-1:0]  FN_REGJUMP  = 6'd8;
    localparam logic [REGIDX_W-1:0] LINK_INDEX  = 5'd31;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JUMP,
        FLOW_JLINK,
        FLOW_REGJ
    } flow_e;

    typedef struct packed {
        flow_e              kind;
        logic [IMM_W-1:0]   offset;
        logic [INDEX_W-1:0] index;
    } decode_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0] instr,
    output decode_t           dec
);
    logic [OPC_W-1:0]   opc;
    logic [FUNCT_W-1:0] fn;

    always_comb begin
        opc        = instr[ADDR_W-1 -: OPC_W];
        fn         = instr[FUNCT_W-1:0];
        dec.offset = instr[IMM_W-1:0];
        dec.index  = instr[INDEX_W-1:0];
        unique case (opc)
            OPC_BREQ:    dec.kind = FLOW_BREQ;
            OPC_BRNE:    dec.kind = FLOW_BRNE;
            OPC_JUMP:    dec.kind = FLOW_JUMP;
            OPC_JLINK:   dec.kind = FLOW_JLINK;
            OPC_SPECIAL: dec.kind = (fn == FN_REGJUMP) ? FLOW_REGJ : FLOW_SEQ;
            default:     dec.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0] pc,
    input  decode_t           dec,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    input  logic [ADDR_W-1:0] jr_target,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic              same;

    always_comb begin
        seq_addr = pc + ADDR_W'(4);
        br_addr  = seq_addr + {{SEXT_W{dec.offset[IMM_W-1]}}, dec.offset, 2'b00};
        jmp_addr = {seq_addr[ADDR_W-1 -: REGION_W], dec.index, 2'b00};
        same     = (rs_val == rt_val);
        unique case (dec.kind)
            FLOW_BREQ:  next_addr = same  ? br_addr : seq_addr;
            FLOW_BRNE:  next_addr = !same ? br_addr : seq_addr;
            FLOW_JUMP,
            FLOW_JLINK: next_addr = jmp_addr;
            FLOW_REGJ:  next_addr = jr_target;
            default:    next_addr = seq_addr;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    input  logic [31:0] jr_target,
    output logic [31:0] pc,
    output logic [31:0] pc_next,
    output logic [31:0] link_addr,
    output logic        link_we,
    output logic [4:0]  link_reg
);
    state_t            state_d, state_q;
    decode_t           dec;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] next_addr;

    npc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    npc_target u_tgt (
        .pc        (state_q.pc),
        .dec       (dec),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .jr_target (jr_target),
        .seq_addr  (seq_addr),
        .next_addr (next_addr)
    );

    always_comb begin
        state_d = state_q;
        if (step_en) begin
            state_d.pc = next_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc        = state_q.pc;
    assign pc_next   = next_addr;
    assign link_we   = (dec.kind == FLOW_JLINK);
    assign link_addr = seq_addr;
    assign link_reg  = LINK_INDEX;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        step_en,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] jr_target,
    input logic [31:0] pc,
    input logic [31:0] pc_next,
    input logic [31:0] link_addr,
    input logic        link_we,
    input logic [4:0]  link_reg
);
    logic [5:0]  op;
    logic [31:0] after;
    assign op    = instr[31:26];
    assign after = pc + 32'd4;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc)); // R2
    AST_TAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> pc == $past(pc_next)); // R3
    AST_PLAIN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 6'd5 || op == 6'd1) |-> pc_next == after); // R3
    AST_EQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd4 && rs_val != rt_val) |-> pc_next == after); // R4
    AST_NE_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd5 && rs_val == rt_val) |-> pc_next == after); // R5
    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd2) |-> (pc_next[31:28] == after[31:28] && pc_next[1:0] == 2'b00)); // R7
    AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (op == 6'd3 && link_addr == after && link_reg == 5'd31)); // R8
    AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd0 && instr[5:0] == 6'd8) |-> pc_next == jr_target); // R9
endmodule

bind npc_unit npc_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .jr_target (jr_target),
    .pc        (pc),
    .pc_next   (pc_next),
    .link_addr (link_addr),
    .link_we   (link_we),
    .link_reg  (link_reg)
);

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] jr_target = 32'h0;
    logic [31:0] pc, pc_next, link_addr;
    logic        link_we;
    logic [4:0]  link_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model_pc;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .jr_target(jr_target),
        .pc(pc), .pc_next(pc_next), .link_addr(link_addr),
        .link_we(link_we), .link_reg(link_reg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd9, 5'd10, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction
    function automatic logic [31:0] enc_r(input logic [5:0] fn);
        return {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, fn};
    endfunction

    // Expected next address, written from the requirement list
    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] ins,
                                             input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] r);
        logic [31:0] p4, off;
        p4  = p + 32'd4;
        off = {{14{ins[15]}}, ins[15:0], 2'b00};
        case (ins[31:26])
            6'd4:       return (a == b) ? p4 + off : p4;          // R4
            6'd5:       return (a != b) ? p4 + off : p4;          // R5
            6'd2, 6'd3: return {p4[31:28], ins[25:0], 2'b00};     // R7
            6'd0:       return (ins[5:0] == 6'd8) ? r : p4;       // R9
            default:    return p4;                                // R3
        endcase
    endfunction

    task automatic step(input string tag, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] r, input logic en);
        logic [31:0] nx;
        @(negedge clk);
        instr = ins; rs_val = a; rt_val = b; jr_target = r; step_en = en;
        #1;
        nx = ref_next(model_pc, ins, a, b, r);
        chk({tag, " pc_next"}, pc_next, nx);
        chk("R8 link_we", {31'd0, link_we}, {31'd0, ins[31:26] == 6'd3});
        if (ins[31:26] == 6'd3) begin
            chk("R8 link_addr", link_addr, model_pc + 32'd4);
            chk("R8 link_reg", {27'd0, link_reg}, 32'd31);
        end
        if (en) model_pc = nx;
        exp_q.push_back(model_pc);
        tag_q.push_back(en ? "R3 pc advance" : "R2 pc hold");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pc update is due one rising edge after the driver's step
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, pc, e);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        model_pc = 32'h0040_0000;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pc", pc, 32'h0040_0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 pc after release", pc, 32'h0040_0000);

        step("R9 funct!=8 seq", enc_r(6'd32), 0, 0, 32'h1234, 1'b1);
        step("R2 idle jump", enc_j(6'd2, 26'h3F_0000), 0, 0, 0, 1'b0);
        step("R3 other opcode", enc_i(6'd8, 16'hFFCE), 0, 0, 0, 1'b1);
        step("R3 opcode1", enc_i(6'd1, 16'h0010), 1, 2, 0, 1'b1);
        step("R4 beq taken", enc_i(6'd4, 16'd3), 32'h55, 32'h55, 0, 1'b1);
        step("R4 beq not taken", enc_i(6'd4, 16'd3), 32'h55, 32'h56, 0, 1'b1);
        step("R6 bne back", enc_i(6'd5, 16'hFFFE), 32'h1, 32'h2, 0, 1'b1);
        step("R5 bne not taken", enc_i(6'd5, 16'h0040), 32'h7, 32'h7, 0, 1'b1);
        step("R6 beq back", enc_i(6'd4, 16'h8000), 32'h0, 32'h0, 0, 1'b1);
        step("R7 jump", enc_j(6'd2, 26'h010_0000), 0, 0, 0, 1'b1);
        step("R8 jal", enc_j(6'd3, 26'h000_1234), 0, 0, 0, 1'b1);
        step("R9 jr", enc_r(6'd8), 0, 0, 32'h0FFF_FFFC, 1'b1);
        step("R10 jump region", enc_j(6'd2, 26'd5), 0, 0, 0, 1'b1);
        chk("R10 explicit target", model_pc, 32'h1000_0014);
        step("R9 jr high", enc_r(6'd8), 0, 0, 32'hFFFF_FFFC, 1'b1);
        step("R11 wrap", enc_i(6'd35, 16'h0), 0, 0, 0, 1'b1);
        chk("R11 explicit wrap", model_pc, 32'h0);
        step("R2 idle branch", enc_i(6'd4, 16'd8), 3, 3, 0, 1'b0);
        @(posedge clk);
        #5;
        done = 1'b1;
        finish_run();
    end
endmodule